// File: doc/BRIEF.md
# Ancillary Data Packet Inserter

This block turns user packet bytes into a 10-bit ancillary data packet for a video multiplexer. While multiplexing is enabled and no packet is in progress, it offers a slot with a one-cycle ready pulse. The user confirms the slot by driving the enable input high in the second cycle after that pulse. The user then places the packet bytes on an 8-bit bus, one per cycle and in strict order: data identifier, secondary identifier (or block number), data count, then the user data words.

The block emits a gap-free word stream with a valid strobe. The stream opens with the three-word packet flag. Each user byte follows, widened to 10 bits with an even-parity bit and its inverse. The stream closes with a generated checksum word. The block reads the packet length from the data count byte. If the enable does not arrive in the required cycle, the block abandons the slot and pulses an error flag.

Top module: `anc_pkt_inserter`

## Requirements
- R1: When idle with `mux_en_i` high, the block raises `pkt_rdy_o` for exactly one cycle. It does not raise it again until the packet ends or the slot is rejected, and it never raises it while `anc_vld_o` is high.
- R2: While `mux_en_i` is low at the clock edge, `pkt_rdy_o` stays low and no packet is produced.
- R3: Call the cycle in which `pkt_rdy_o` is high cycle c. `pkt_en_i` is sampled only in cycle c+2, and a high value there accepts the slot. The value of `pkt_en_i` in any other cycle has no effect.
- R4: After an accepted slot, `anc_vld_o` is high in every cycle from c+3 through c+6+N, where N = 3 + data count. The words are 0x000 in c+3 and 0x3FF in c+4 and c+5. Byte i is sampled from `pkt_byte_i` in cycle c+4+i, and its formatted word appears in cycle c+6+i.
- R5: Each formatted word holds the byte in bits 7:0. Bit 8 is the XOR of bits 7:0, so bits 8:0 carry even parity, and bit 9 is the inverse of bit 8.
- R6: The third byte (data count, 0 to 255) sets how many user data words follow it. The checksum comes right after the last of them, even when the count is 0, and bytes on the bus after that point are ignored. `anc_vld_o` is low in cycle c+7+N.
- R7: Bits 8:0 of the checksum word are the modulo-512 sum of bits 8:0 of every formatted word from the identifier through the last user data word. Bit 9 of the checksum is the inverse of its bit 8.
- R8: If `pkt_en_i` is low in cycle c+2, no word is emitted and `hs_err_o` is high for cycle c+3 only. With `mux_en_i` still high, `pkt_rdy_o` rises again in cycle c+4.
- R9: During reset, `pkt_rdy_o`, `hs_err_o` and `anc_vld_o` are low and `anc_word_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mux_en_i | input | 1 | Multiplex operation enable; gates slot offers |
| pkt_en_i | input | 1 | User enable confirming an offered slot |
| pkt_byte_i | input | 8 | User packet byte, bit 7 most significant |
| pkt_rdy_o | output | 1 | One-cycle slot offer |
| hs_err_o | output | 1 | One-cycle pulse when the enable missed its cycle |
| anc_word_o | output | 10 | Formatted packet word |
| anc_vld_o | output | 1 | Qualifies `anc_word_o` |

## Verification
The assertions assume the user honours the fixed byte cadence: once a slot is accepted, a byte of the packet is present on the bus in every cycle until the data count is reached. The assertions also assume `mux_en_i` changes only between packets. The stimulus always feeds the bytes back to back from cycle c+4. It drives junk on the bus after the last byte and toggles the enable freely outside the sampled cycle. It lowers the mode enable only while no slot or packet is in progress.

// File: rtl/anc_pkg.sv
package anc_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned WORD_W    = BYTE_W + 2;
  localparam int unsigned SUM_W     = BYTE_W + 1;
  localparam int unsigned IDX_W     = BYTE_W + 1;
  localparam int unsigned HDR_BYTES = 3;   // id, secondary id, count
  localparam int unsigned FLAG_LEN  = 3;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [SUM_W-1:0]  sum_t;

  localparam word_t FLAG_FIRST = '0;
  localparam word_t FLAG_REST  = '1;

  typedef enum logic [1:0] {HS_IDLE, HS_WAIT, HS_BUSY} hs_state_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_FLAG, SQ_DATA, SQ_CSUM} sq_state_e;
endpackage

// File: rtl/anc_handshake.sv
module anc_handshake
  import anc_pkg::*;
#(
  parameter int unsigned EN_LAG = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mux_en_i,
  input  logic en_i,
  input  logic done_i,
  output logic rdy_o,
  output logic go_o,
  output logic err_o
);
  localparam int unsigned CNT_W = $clog2(EN_LAG + 1);

  hs_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rdy_q, err_q;
  logic             at_check;

  assign at_check = (st_q == HS_WAIT) && (cnt_q == CNT_W'(EN_LAG));
  assign go_o     = at_check && en_i;
  assign rdy_o    = rdy_q;
  assign err_o    = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= HS_IDLE;
      cnt_q <= '0;
      rdy_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      rdy_q <= 1'b0;
      err_q <= 1'b0;
      unique case (st_q)
        HS_IDLE: if (mux_en_i) begin
          st_q  <= HS_WAIT;
          cnt_q <= '0;
          rdy_q <= 1'b1;
        end
        HS_WAIT: if (at_check) begin
          st_q  <= en_i ? HS_BUSY : HS_IDLE;
          err_q <= !en_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        HS_BUSY: if (done_i) st_q <= HS_IDLE;
        default: st_q <= HS_IDLE;
      endcase
    end
  end

  AST_RDY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o); // R1
  AST_RDY_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> $past(mux_en_i)); // R2
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R8
endmodule

// File: rtl/anc_word_fmt.sv
module anc_word_fmt
  import anc_pkg::*;
(
  input  byte_t byte_i,
  output word_t word_o
);
  logic par;
  assign par    = ^byte_i;           // even over bits 8:0
  assign word_o = {~par, par, byte_i};
endmodule

// File: rtl/anc_csum.sv
module anc_csum
  import anc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  add_i,
  input  sum_t  val_i,
  output word_t csum_o
);
  sum_t sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else if (add_i) sum_q <= sum_q + val_i;   // carry out dropped
  end

  assign csum_o = {~sum_q[SUM_W-1], sum_q};
endmodule

// File: rtl/anc_sequencer.sv
module anc_sequencer
  import anc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  go_i,
  input  byte_t byte_i,
  output logic  done_o,
  output word_t word_o,
  output logic  vld_o
);
  localparam int unsigned FIDX_W = $clog2(FLAG_LEN);
  localparam logic [IDX_W-1:0] DC_IDX = IDX_W'(HDR_BYTES - 1);

  sq_state_e         st_q;
  logic [FIDX_W-1:0] fidx_q;
  logic [IDX_W-1:0]  idx_q;
  byte_t             hold_q, dc_q, dc_eff;
  word_t             fmt_w, csum_w, word_q;
  logic              vld_q, last_w, in_data, in_csum;

  anc_word_fmt u_fmt (.byte_i(hold_q), .word_o(fmt_w));

  assign in_data = (st_q == SQ_DATA);
  assign in_csum = (st_q == SQ_CSUM);

  anc_csum u_csum (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (in_csum),
    .add_i (in_data),
    .val_i (fmt_w[SUM_W-1:0]),
    .csum_o(csum_w)
  );

  // count byte is still in hold_q while it is being emitted
  assign dc_eff = (idx_q == DC_IDX) ? hold_q : dc_q;
  assign last_w = (idx_q == DC_IDX + {1'b0, dc_eff});
  assign done_o = in_csum;
  assign word_o = word_q;
  assign vld_o  = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      fidx_q <= '0;
      idx_q  <= '0;
      hold_q <= '0;
      dc_q   <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          vld_q <= go_i;
          if (go_i) begin
            word_q <= FLAG_FIRST;
            fidx_q <= FIDX_W'(1);
            st_q   <= SQ_FLAG;
          end
        end
        SQ_FLAG: begin
          word_q <= FLAG_REST;
          vld_q  <= 1'b1;
          if (fidx_q == FIDX_W'(FLAG_LEN - 1)) begin
            hold_q <= byte_i;
            idx_q  <= '0;
            st_q   <= SQ_DATA;
          end else begin
            fidx_q <= fidx_q + 1'b1;
          end
        end
        SQ_DATA: begin
          word_q <= fmt_w;
          vld_q  <= 1'b1;
          if (idx_q == DC_IDX) dc_q <= hold_q;
          if (last_w) begin
            st_q <= SQ_CSUM;
          end else begin
            hold_q <= byte_i;
            idx_q  <= idx_q + 1'b1;
          end
        end
        SQ_CSUM: begin
          word_q <= csum_w;
          vld_q  <= 1'b1;
          st_q   <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  AST_STREAM_GAPLESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && st_q != SQ_IDLE) |=> vld_o); // R4
  AST_CSUM_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && st_q == SQ_IDLE) |=> !vld_o); // R6
endmodule

// File: rtl/anc_pkt_inserter.sv
module anc_pkt_inserter
  import anc_pkg::*;
#(
  parameter int unsigned EN_LAG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mux_en_i,
  input  logic              pkt_en_i,
  input  logic [BYTE_W-1:0] pkt_byte_i,
  output logic              pkt_rdy_o,
  output logic              hs_err_o,
  output logic [WORD_W-1:0] anc_word_o,
  output logic              anc_vld_o
);
  logic go, done;

  anc_handshake #(.EN_LAG(EN_LAG)) u_hs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mux_en_i(mux_en_i),
    .en_i    (pkt_en_i),
    .done_i  (done),
    .rdy_o   (pkt_rdy_o),
    .go_o    (go),
    .err_o   (hs_err_o)
  );

  anc_sequencer u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (go),
    .byte_i(pkt_byte_i),
    .done_o(done),
    .word_o(anc_word_o),
    .vld_o (anc_vld_o)
  );

  AST_NO_OFFER_IN_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    anc_vld_o |-> !pkt_rdy_o); // R1
  AST_ERR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_err_o |-> !anc_vld_o); // R8
endmodule

// File: tb/tb_anc_pkt_inserter.sv
`timescale 1ns/1ps
module tb_anc_pkt_inserter;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mux_en_i = 1'b0;
  logic       pkt_en_i = 1'b0;
  logic [7:0] pkt_byte_i = '0;
  logic       pkt_rdy_o, hs_err_o, anc_vld_o;
  logic [9:0] anc_word_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] pbuf [0:259];

  always #2.5 clk = ~clk;

  anc_pkt_inserter dut (
    .clk_i(clk), .rst_ni(rst_ni), .mux_en_i(mux_en_i), .pkt_en_i(pkt_en_i),
    .pkt_byte_i(pkt_byte_i), .pkt_rdy_o(pkt_rdy_o), .hs_err_o(hs_err_o),
    .anc_word_o(anc_word_o), .anc_vld_o(anc_vld_o)
  );

  function automatic logic [9:0] fmt(input logic [7:0] b);
    return {~(^b), ^b, b};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] did, input logic [7:0] sdid,
                      input logic [7:0] dc, input int mode);
    pbuf[0] = did; pbuf[1] = sdid; pbuf[2] = dc;
    for (int i = 3; i < 3 + int'(dc); i++)
      pbuf[i] = (mode == 1) ? 8'h00 : (mode == 2) ? 8'hFF : 8'($urandom);
  endtask

  task automatic wait_rdy();
    int t = 0;
    while (!pkt_rdy_o && t < 20) begin @(negedge clk); t++; end
    chk(pkt_rdy_o === 1'b1, "R1 ready offer", int'(pkt_rdy_o), 1);
  endtask

  // ok: enable in cycle c+2; early: enable in c+1 and c+3; drop: mode off after reject
  task automatic run_pkt(input bit ok, input bit early, input bit drop);
    int n;
    logic [8:0] s;
    logic [9:0] exp;
    n = 3 + int'(pbuf[2]);
    wait_rdy();                          // cycle c
    pkt_en_i = 1'b0;
    @(negedge clk); pkt_en_i = early;    // c+1
    chk(pkt_rdy_o === 1'b0, "R1 ready one cycle", int'(pkt_rdy_o), 0);
    @(negedge clk); pkt_en_i = ok;       // c+2
    @(negedge clk); pkt_en_i = early;    // c+3
    if (!ok) begin
      chk(hs_err_o === 1'b1 && anc_vld_o === 1'b0, "R8 reject error",
          {hs_err_o, anc_vld_o}, 2'b10);
      if (!early) pkt_en_i = 1'b0;
      if (drop) mux_en_i = 1'b0;
      @(negedge clk);                    // c+4
      pkt_en_i = 1'b0;
      chk(hs_err_o === 1'b0 && anc_vld_o === 1'b0, "R8 error one cycle",
          {hs_err_o, anc_vld_o}, 0);
      if (drop) begin
        for (int i = 0; i < 10; i++) begin
          chk(pkt_rdy_o === 1'b0 && anc_vld_o === 1'b0, "R2 no offer when mode off",
              {pkt_rdy_o, anc_vld_o}, 0);
          @(negedge clk);
        end
        mux_en_i = 1'b1;
      end else begin
        chk(pkt_rdy_o === 1'b1, "R8 reoffer at c+4", int'(pkt_rdy_o), 1);
      end
      return;
    end
    s = '0;
    for (int k = 0; k < n + 4; k++) begin   // cycle c+3+k
      if (k == 0) exp = 10'h000;
      else if (k < 3) exp = 10'h3FF;
      else if (k < n + 3) begin
        exp = fmt(pbuf[k-3]);
        s = s + exp[8:0];
      end else exp = {~s[8], s};
      chk(anc_vld_o === 1'b1 && anc_word_o === exp,
          (k < 3) ? "R4 flag word" : (k < n + 3) ? "R5 data word" : "R7 checksum",
          {anc_vld_o, anc_word_o}, {1'b1, exp});
      pkt_byte_i = (k >= 1 && k - 1 < n) ? pbuf[k-1] : 8'($urandom);
      pkt_en_i = 1'($urandom);             // R3 ignored outside c+2
      @(negedge clk);
    end
    pkt_en_i = 1'b0;                        // cycle c+7+n
    chk(anc_vld_o === 1'b0 && pkt_rdy_o === 1'b1, "R6 packet end",
        {anc_vld_o, pkt_rdy_o}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A1C));
    repeat (3) @(negedge clk);
    chk(pkt_rdy_o === 0 && hs_err_o === 0 && anc_vld_o === 0 && anc_word_o === 0,
        "R9 reset state", {pkt_rdy_o, hs_err_o, anc_vld_o, anc_word_o}, 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(pkt_rdy_o === 1'b0, "R2 mode off", int'(pkt_rdy_o), 0);
    end
    mux_en_i = 1'b1;
    @(negedge clk);

    fill(8'h41, 8'h05, 8'd0, 0);   run_pkt(1, 0, 0);  // R6 zero count
    fill(8'h00, 8'h00, 8'd0, 1);   run_pkt(1, 0, 0);  // R7 all-zero sum
    fill(8'hFF, 8'hFF, 8'd255, 2); run_pkt(1, 0, 0);  // R6 max count, R7 wrap
    fill(8'h60, 8'h60, 8'd4, 0);   run_pkt(0, 0, 0);  // R8 missing enable
    fill(8'h61, 8'h01, 8'd3, 0);   run_pkt(0, 1, 0);  // R3 early/late enable only
    fill(8'h62, 8'h02, 8'd2, 0);   run_pkt(1, 1, 0);  // R3 extra enable ignored
    fill(8'h63, 8'h03, 8'd1, 0);   run_pkt(0, 0, 1);  // R2 mode dropped
    for (int p = 0; p < 24; p++) begin
      fill(8'($urandom), 8'($urandom), 8'($urandom_range(0, 20)), 0);
      run_pkt(($urandom_range(0, 3) != 0), 1'($urandom), 1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule